// File: doc/BRIEF.md
# 8-bit Timer with Output Compare

This block is an 8-bit timer/counter with a single output-compare channel, meant for a microcontroller-style peripheral. It advances on a timer tick. The tick comes from a prescaler. The prescaler counts either bus-clock cycles or rising edges of a free-running oscillator input that is asynchronous to the bus clock. That oscillator input passes through a synchronizer before it is used, so every event and status flag is produced in the bus-clock domain.

The compare value is double-buffered. Software writes a buffer, and the value used by the comparator (the active value) is taken from that buffer at a point that depends on the mode. On every tick the count is compared with the active value. A match raises a compare flag. Reaching the count limit raises an overflow flag. Four modes shape the count sequence and the waveform output: free-running, clear-on-match with a toggling output, fast PWM and up/down (phase-correct) PWM. Each flag raises an interrupt request only when its mask bit is set.

Software reaches the block through a single-cycle write port and a combinational read port, each with a 2-bit register address.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_ovf`, `irq_cmp` and `wave_out` are low.
- R2: Register addresses are 0 = control, 1 = count, 2 = compare, 3 = flags/mask. In the control register, bits [2:0] select the clock, bit 3 selects the oscillator source, bits [5:4] select the mode, and bits [7:6] read as zero. When the clock-select field is 0, the count holds its value.
- R3: Clock-select values 1 to 7 divide the tick source by 1, 8, 32, 64, 128, 256 and 1024. Over N consecutive source events, a divisor D gives exactly N/D ticks when D divides N.
- R4: When bit 3 of the control register is 1, ticks come only from rising edges of `osc_in`, after a two-stage synchronizer. With `osc_in` held still, the count does not move.
- R5: In mode 0 (free-running) and mode 2 (fast PWM), each tick adds one and the count wraps from 0xFF to 0x00. A tick taken at 0xFF sets the overflow flag (flags bit 0).
- R6: A tick taken while the count equals the active compare value sets the compare flag (flags bit 1), in every mode.
- R7: In mode 1 (clear on match), a tick at a match loads 0x00 into the count and toggles `wave_out`.
- R8: In modes 0 and 1, a compare write takes effect at once. In modes 2 and 3, the write goes to a buffer, which is copied to the active value on a tick taken at 0xFF. A read of address 2 returns the active value.
- R9: In modes 2 and 3, `wave_out` is high while the count is less than the active compare value. In mode 0 it is low.
- R10: In mode 3, the count rises to 0xFF, then falls to 0x00, then rises again. A tick taken at 0x00 while falling loads 0x01 and sets the overflow flag.
- R11: A write to address 3 clears each flag whose bit in [1:0] is 1 and loads the mask from bits [5:4] (bit 4 = overflow, bit 5 = compare). A 0 in [1:0] leaves that flag as it is. The `irq_ack_*` inputs also clear their flag. A new event in the same cycle wins over a clear. Each `irq_*` output is its flag AND its mask bit. A read of address 3 returns {00, mask, 00, flags}.
- R12: A write to address 1 loads the count and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Combinational read data |
| osc_in | input | 1 | Asynchronous oscillator input |
| irq_ack_ovf | input | 1 | Interrupt service acknowledge, overflow |
| irq_ack_cmp | input | 1 | Interrupt service acknowledge, compare |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| wave_out | output | 1 | Waveform output |

## Verification
A register write takes effect at the clock edge that samples it. A tick acts at the edge where it is present, and any flag it raises is readable in the following cycle, with `irq_*` following that flag combinationally. A timed run therefore starts and stops the clock through control-register writes, and the number of ticks equals the number of edges between those two writes, each counted as it happens. An oscillator edge needs two synchronizer stages and one edge-detect stage before it ticks, so the bench leaves several idle cycles before it stops the timer. All reads and port samples are taken at the falling edge, after the counter has stopped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W = 8;
    localparam int PRE_W = 10;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_FAST   = 2'd2,
        MODE_PHASE  = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CMP   = 2'd2,
        REG_FLAGS = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        tmr_mode_e  mode;
        logic       osc_src;
        logic [2:0] csel;
    } tmr_ctrl_t;

    typedef struct packed {
        logic cmp;
        logic ovf;
    } tmr_evt_t;

    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] csel);
        case (csel)
            3'd2:    return PRE_W'(7);
            3'd3:    return PRE_W'(31);
            3'd4:    return PRE_W'(63);
            3'd5:    return PRE_W'(127);
            3'd6:    return PRE_W'(255);
            3'd7:    return PRE_W'(1023);
            default: return '0;
        endcase
    endfunction

    function automatic logic is_pwm(input tmr_mode_e m);
        return (m == MODE_FAST) || (m == MODE_PHASE);
    endfunction

endpackage

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
    import tmr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] csel,
    input  logic       osc_src,
    input  logic       osc_in,
    output logic       tick
);
    logic [SYNC_N-1:0] sync_q;
    logic              osc_prev_q;
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  mask;
    logic              src_evt;

    assign src_evt = osc_src ? (sync_q[SYNC_N-1] & ~osc_prev_q) : 1'b1;
    assign mask    = div_mask(csel);
    assign tick    = (csel != 3'd0) && src_evt && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '0;
            osc_prev_q <= 1'b0;
            pre_q      <= '0;
        end else begin
            sync_q     <= {sync_q[SYNC_N-2:0], osc_in};
            osc_prev_q <= sync_q[SYNC_N-1];
            if (src_evt) pre_q <= pre_q + 1'b1;
        end
    end

    // R4: in oscillator mode a tick needs a synchronized rising edge
    assert_osc_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (osc_src && tick) |=> $past(sync_q[SYNC_N-1]) && !osc_prev_q == 1'b0);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic      clk,
    input  logic      rst,
    input  tmr_mode_e mode,
    input  logic      tick,
    input  logic      cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic      cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cmp_act,
    output logic      wave,
    output tmr_evt_t  evt
);
    logic [W-1:0] cnt_q, cnt_d, cmp_act_q, cmp_buf_q;
    logic         dir_up_q, dir_d, tog_q, ovf;
    logic         at_top, at_bot, hit;

    assign at_top = (cnt_q == '1);
    assign at_bot = (cnt_q == '0);
    assign hit    = (cnt_q == cmp_act_q);

    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_up_q;
        ovf   = 1'b0;
        if (tick) begin
            case (mode)
                MODE_NORMAL, MODE_FAST: begin
                    cnt_d = cnt_q + 1'b1;
                    ovf   = at_top;
                end
                MODE_CTC: begin
                    cnt_d = hit ? '0 : cnt_q + 1'b1;
                    ovf   = at_top;
                end
                default: begin
                    if (dir_up_q) begin
                        if (at_top) begin
                            cnt_d = cnt_q - 1'b1;
                            dir_d = 1'b0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else if (at_bot) begin
                        cnt_d = cnt_q + 1'b1;
                        dir_d = 1'b1;
                        ovf   = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
        if (mode != MODE_PHASE) dir_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            dir_up_q  <= 1'b1;
            tog_q     <= 1'b0;
            cmp_buf_q <= '0;
            cmp_act_q <= '0;
        end else begin
            cnt_q    <= cnt_wr ? cnt_wdata : cnt_d;
            dir_up_q <= dir_d;
            if (tick && (mode == MODE_CTC) && hit) tog_q <= ~tog_q;
            if (cmp_wr) cmp_buf_q <= cmp_wdata;
            if (cmp_wr && !is_pwm(mode))
                cmp_act_q <= cmp_wdata;
            else if (is_pwm(mode) && tick && at_top)
                cmp_act_q <= cmp_buf_q;
        end
    end

    always_comb begin
        case (mode)
            MODE_NORMAL: wave = 1'b0;
            MODE_CTC:    wave = tog_q;
            default:     wave = (cnt_q < cmp_act_q);
        endcase
    end

    assign cnt     = cnt_q;
    assign cmp_act = cmp_act_q;
    assign evt.ovf = ovf;
    assign evt.cmp = tick && hit;

    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    assert_wrap_top_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && at_top && (mode == MODE_NORMAL || mode == MODE_FAST))
        |=> (cnt_q == '0));

    assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (is_pwm(mode) && !(tick && at_top)) |=> $stable(cmp_act_q));

    assert_phase_bottom_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PHASE && tick && !cnt_wr && !dir_up_q && at_bot)
        |=> (cnt_q == W'(1) && dir_up_q));

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_evt,
    input  logic [NSRC-1:0] clr_w1c,
    input  logic [NSRC-1:0] clr_ack,
    input  logic            mask_wr,
    input  logic [NSRC-1:0] mask_wdata,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] irq
);
    logic [NSRC-1:0] flag_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            mask_q <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (set_evt[i])                  flag_q[i] <= 1'b1;
                else if (clr_w1c[i] | clr_ack[i]) flag_q[i] <= 1'b0;
            end
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign irq[i] = flag_q[i] & mask_q[i];

        assert_flag_cause_R11: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q[i]) |-> $past(set_evt[i]));

        assert_ack_clears_R11: assert property (@(posedge clk) disable iff (rst)
            (clr_ack[i] && !set_evt[i]) |=> !flag_q[i]);
    end

    assign flags = flag_q;
    assign mask  = mask_q;

endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
    import tmr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       osc_in,
    input  logic       irq_ack_ovf,
    input  logic       irq_ack_cmp,
    output logic       irq_ovf,
    output logic       irq_cmp,
    output logic       wave_out
);
    tmr_ctrl_t        ctrl_q;
    logic             tick;
    logic [CNT_W-1:0] cnt, cmp_act;
    tmr_evt_t         evt;
    logic [1:0]       flags, mask, irq;
    logic             wr_ctrl, wr_cnt, wr_cmp, wr_flags;

    assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
    assign wr_cnt   = wr_en && (wr_addr == REG_COUNT);
    assign wr_cmp   = wr_en && (wr_addr == REG_CMP);
    assign wr_flags = wr_en && (wr_addr == REG_FLAGS);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wr_data[5:0];
    end

    tmr_clk_sel #(.SYNC_N(SYNC_N)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .csel    (ctrl_q.csel),
        .osc_src (ctrl_q.osc_src),
        .osc_in  (osc_in),
        .tick    (tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .mode      (ctrl_q.mode),
        .tick      (tick),
        .cnt_wr    (wr_cnt),
        .cnt_wdata (wr_data),
        .cmp_wr    (wr_cmp),
        .cmp_wdata (wr_data),
        .cnt       (cnt),
        .cmp_act   (cmp_act),
        .wave      (wave_out),
        .evt       (evt)
    );

    tmr_flags #(.NSRC(2)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .set_evt    (evt),
        .clr_w1c    (wr_flags ? wr_data[1:0] : 2'b00),
        .clr_ack    ({irq_ack_cmp, irq_ack_ovf}),
        .mask_wr    (wr_flags),
        .mask_wdata (wr_data[5:4]),
        .flags      (flags),
        .mask       (mask),
        .irq        (irq)
    );

    assign irq_ovf = irq[0];
    assign irq_cmp = irq[1];

    always_comb begin
        case (rd_addr)
            REG_CTRL:  rd_data = {2'b00, ctrl_q};
            REG_COUNT: rd_data = cnt;
            REG_CMP:   rd_data = cmp_act;
            default:   rd_data = {2'b00, mask, 2'b00, flags};
        endcase
    end

    // R1: interrupt requests stay low while reset is applied
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_ovf && !irq_cmp));

endmodule

// File: tb/tmr8_cmp_tb.sv
`timescale 1ns/1ps
module tmr8_cmp_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       osc_in = 1'b0;
    logic       irq_ack_ovf = 1'b0;
    logic       irq_ack_cmp = 1'b0;
    logic       irq_ovf, irq_cmp, wave_out;

    typedef struct {
        logic [1:0] addr;
        logic [7:0] exp;
        bit         port;
        string      tag;
    } item_t;

    item_t item_q[$];
    item_t cur;
    logic [7:0] got;
    int vectors = 0;
    int miscomp = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr8_cmp u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .osc_in(osc_in),
        .irq_ack_ovf(irq_ack_ovf), .irq_ack_cmp(irq_ack_cmp),
        .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .wave_out(wave_out)
    );

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (item_q.size() > 0) begin
            cur = item_q.pop_front();
            rd_addr = cur.addr;
            #1;
            got = cur.port ? {5'b0, wave_out, irq_cmp, irq_ovf} : rd_data;
            vectors++;
            if (got !== cur.exp) begin
                miscomp++;
                $display("FAIL %s: actual %h expected %h", cur.tag, got, cur.exp);
            end
        end
    end

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.port = 1'b0; it.tag = tag;
        item_q.push_back(it);
        wait (item_q.size() == 0);
    endtask

    // port bits: {wave_out, irq_cmp, irq_ovf}
    task automatic expect_port(input logic [2:0] e, input string tag);
        item_t it;
        it.addr = 2'd0; it.exp = {5'b0, e}; it.port = 1'b1; it.tag = tag;
        item_q.push_back(it);
        wait (item_q.size() == 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    function automatic logic [7:0] cb(input int m, input bit a, input int c);
        logic [1:0] mm = m[1:0];
        logic [2:0] cc = c[2:0];
        return {2'b00, mm, a, cc};
    endfunction

    // exactly n ticking edges between the start and the stop write
    task automatic run(input int m, input bit a, input int c, input int n);
        wr(2'd0, cb(m, a, c));
        if (n > 2) idle(n - 2);
        wr(2'd0, cb(m, a, 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscomp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(posedge clk); #1; rst = 1'b0;

        // R1 reset state
        expect_reg(2'd0, 8'h00, "R1 ctrl");
        expect_reg(2'd1, 8'h00, "R1 count");
        expect_reg(2'd2, 8'h00, "R1 cmp");
        expect_reg(2'd3, 8'h00, "R1 flags");
        expect_port(3'b000, "R1 ports");

        // R12 count load, R2 stopped hold
        wr(2'd1, 8'h05);
        idle(10);
        expect_reg(2'd1, 8'h05, "R2 R12 stopped hold");

        // R8 immediate in free-running mode, R5 wrap/overflow, R6 compare flag
        wr(2'd2, 8'h02);
        expect_reg(2'd2, 8'h02, "R8 immediate compare");
        wr(2'd1, 8'hFA);
        run(0, 1'b0, 1, 10);
        expect_reg(2'd1, 8'h04, "R5 wrap count");
        expect_reg(2'd3, 8'h03, "R5 R6 flags");
        expect_port(3'b000, "R11 masked");
        wr(2'd3, 8'h30);
        expect_reg(2'd3, 8'h33, "R11 zero bits keep flags");
        expect_port(3'b011, "R11 both irq");
        wr(2'd3, 8'h31);
        expect_reg(2'd3, 8'h32, "R11 w1c overflow");
        expect_port(3'b010, "R11 irq after w1c");
        @(posedge clk); #1; irq_ack_cmp = 1'b1;
        @(posedge clk); #1; irq_ack_cmp = 1'b0;
        expect_reg(2'd3, 8'h30, "R11 ack clears");
        expect_port(3'b000, "R11 irq after ack");
        wr(2'd3, 8'h03);

        // R3 prescaler
        wr(2'd1, 8'h00);
        run(0, 1'b0, 2, 80);
        expect_reg(2'd1, 8'h0A, "R3 divide 8");
        wr(2'd1, 8'h00);
        run(0, 1'b0, 7, 2048);
        expect_reg(2'd1, 8'h02, "R3 divide 1024");

        // R7 clear on match
        wr(2'd0, cb(1, 1'b0, 0));
        wr(2'd2, 8'h04);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h03);
        run(1, 1'b0, 1, 12);
        expect_reg(2'd1, 8'h02, "R7 count clears");
        expect_port(3'b000, "R7 two toggles");
        expect_reg(2'd3, 8'h02, "R6 compare flag");
        run(1, 1'b0, 1, 5);
        expect_reg(2'd1, 8'h02, "R7 count again");
        expect_port(3'b100, "R7 third toggle");

        // R8 buffered compare, R9 fast PWM wave
        wr(2'd0, cb(2, 1'b0, 0));
        wr(2'd2, 8'h80);
        expect_reg(2'd2, 8'h04, "R8 buffered hold");
        wr(2'd3, 8'h03);
        wr(2'd1, 8'hFE);
        run(2, 1'b0, 1, 2);
        expect_reg(2'd1, 8'h00, "R5 fast wrap");
        expect_reg(2'd2, 8'h80, "R8 copy at top");
        expect_reg(2'd3, 8'h01, "R5 fast overflow");
        expect_port(3'b100, "R9 wave high below compare");
        wr(2'd1, 8'h90);
        expect_port(3'b000, "R9 wave low above compare");

        // R10 up/down mode
        wr(2'd0, cb(3, 1'b0, 0));
        wr(2'd3, 8'h03);
        wr(2'd1, 8'hFE);
        run(3, 1'b0, 1, 3);
        expect_reg(2'd1, 8'hFD, "R10 turn at top");
        expect_reg(2'd3, 8'h00, "R10 no overflow at top");
        wr(2'd1, 8'h01);
        run(3, 1'b0, 1, 2);
        expect_reg(2'd1, 8'h01, "R10 turn at bottom");
        expect_reg(2'd3, 8'h01, "R10 overflow at bottom");

        // R4 oscillator source
        wr(2'd0, cb(0, 1'b1, 0));
        wr(2'd3, 8'h03);
        wr(2'd1, 8'h10);
        run(0, 1'b1, 1, 20);
        expect_reg(2'd1, 8'h10, "R4 still oscillator");
        wr(2'd0, cb(0, 1'b1, 1));
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #1; osc_in = 1'b1;
            idle(3); #1; osc_in = 1'b0;
            idle(3);
        end
        idle(6);
        wr(2'd0, cb(0, 1'b1, 0));
        expect_reg(2'd1, 8'h15, "R4 five oscillator edges");
        expect_reg(2'd0, 8'h08, "R2 control readback");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule